// File: doc/BRIEF.md
# Reference Clock Divider with Staged Ratio

This block divides the crystal reference clock down to the comparison frequency used by the phase/frequency detector. Once per division period it emits a one-cycle comparison pulse. It also drives a reference output whose shape follows the running count. For a ratio of one, that output is the gated reference clock itself.

Software writes a new ratio into a staging register. The block accepts only ratios that the divider can realise, which are one and every value from the minimum of five up to the top of the 13-bit field. It rejects the other values and raises a one-cycle flag. A separate transfer strobe from the serial port marks the staged value pending. The pending value moves into the running divider only at a terminal count, so a period is never cut short. The block marks that cycle with a load strobe, which the main divider uses to take its own new ratio on the same cycle.

Top module: `refdiv_top`

## Requirements
- R1: A write with a ratio of 1, or of 5 through 8191, replaces the staged ratio. A write of 0, 2, 3 or 4 leaves the staged ratio unchanged, and `wr_illegal` is high for exactly the one cycle that follows the write.
- R2: After reset, `act_ratio` is 5 and `wr_illegal`, `main_load` and `cmp_pulse` are low. The first cycle with `en` high is a terminal count.
- R3: While `en` is high and the active ratio is N, `cmp_pulse` is high for one cycle in every N cycles, and it is never high while `en` is low.
- R4: A write without a transfer strobe never changes `act_ratio`.
- R5: At a terminal count with a transfer pending, `main_load` is high in that cycle. From the next cycle `act_ratio` equals the staged ratio, and the following period has the new length.
- R6: While `en` is low, the count is frozen: `cmp_pulse` stays low and `ref_out` holds its value.
- R7: With a ratio of 1, `cmp_pulse` is high in every enabled cycle and `ref_out` equals the reference clock ANDed with `en`.
- R8: With a ratio N of 5 or more, `ref_out` is high for ceil(N/2) cycles of each N-cycle period. These are the cycles in which the down-count is at least floor(N/2).
- R9: A transfer strobe that arrives in a terminal-count cycle with nothing pending does not commit in that cycle. It commits at the next terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (crystal) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; also gates the ratio-1 bypass |
| wr_valid | input | 1 | Ratio write strobe |
| wr_ratio | input | 13 | Ratio value to stage |
| xfer | input | 1 | Transfer strobe: marks the staged ratio pending |
| cmp_pulse | output | 1 | One-cycle comparison pulse per period |
| ref_out | output | 1 | Programmable reference output |
| wr_illegal | output | 1 | One-cycle flag after a rejected write |
| main_load | output | 1 | Commit strobe shared with the main divider |
| act_ratio | output | 13 | Ratio currently being divided by |

## Verification
The bench steps through a table of ratio writes that mixes legal values with the four illegal ones. After each write it measures the period between pulses. This separates a rejected write, where the old period persists, from an accepted one. The table covers the bypass ratio of one, the lowest legal ratio, odd and even ratios (which tell the high-time rounding apart), and the 13-bit maximum. Directed cases then check three more situations: a staged write that is never transferred, a transfer strobe that lands exactly on a terminal count, and a stretch with `en` low.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  parameter int unsigned RATIO_W_DEF   = 13;
  parameter int unsigned MIN_RATIO_DEF = 5;
  parameter int unsigned RST_RATIO_DEF = 5;

  typedef enum logic {
    OUT_BYPASS = 1'b0,
    OUT_DIVIDE = 1'b1
  } out_mode_e;
endpackage

// File: rtl/refdiv_ratio_buf.sv
module refdiv_ratio_buf #(
  parameter int unsigned W     = 13,
  parameter int unsigned MIN_R = 5,
  parameter int unsigned RST_R = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_ratio,
  input  logic         xfer,
  input  logic         commit,
  output logic [W-1:0] stage_q,
  output logic         pending_q,
  output logic         illegal_q
);
  localparam logic [W-1:0] MIN_V = W'(MIN_R);
  localparam logic [W-1:0] RST_V = W'(RST_R);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic         legal;
  logic [W-1:0] stage_d;
  logic         pending_d;
  logic         illegal_d;

  always_comb begin
    legal     = (wr_ratio == ONE_V) || (wr_ratio >= MIN_V);
    stage_d   = stage_q;
    if (wr_valid && legal) stage_d = wr_ratio;
    pending_d = pending_q;
    if (commit) pending_d = 1'b0;
    if (xfer)   pending_d = 1'b1;
    illegal_d = wr_valid && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= RST_V;
      pending_q <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      stage_q   <= stage_d;
      pending_q <= pending_d;
      illegal_q <= illegal_d;
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned W     = 13,
  parameter int unsigned RST_R = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         pending,
  input  logic [W-1:0] stage,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] active_q,
  output logic         tc,
  output logic         load
);
  localparam logic [W-1:0] RST_V = W'(RST_R);
  localparam logic [W-1:0] ONE_V = W'(1);

  logic [W-1:0] cnt_d;
  logic [W-1:0] active_d;

  always_comb begin
    tc       = en && (cnt_q == '0);
    load     = tc && pending;
    active_d = active_q;
    cnt_d    = cnt_q;
    if (tc) begin
      if (load) active_d = stage;
      cnt_d = active_d - ONE_V;
    end else if (en) begin
      cnt_d = cnt_q - ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= RST_V;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/refdiv_refout.sv
module refdiv_refout
  import refdiv_pkg::*;
#(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         en,
  input  logic         tc,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] active_q,
  output logic         cmp_pulse,
  output logic         ref_out
);
  localparam logic [W-1:0] ONE_V = W'(1);

  out_mode_e    mode;
  logic [W-1:0] half;
  logic         div_hi;

  always_comb begin
    mode      = (active_q == ONE_V) ? OUT_BYPASS : OUT_DIVIDE;
    half      = active_q >> 1;
    div_hi    = (cnt_q >= half);
    cmp_pulse = tc;
    case (mode)
      OUT_BYPASS: ref_out = clk & en;
      default:    ref_out = div_hi;
    endcase
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned RATIO_W   = RATIO_W_DEF,
  parameter int unsigned MIN_RATIO = MIN_RATIO_DEF,
  parameter int unsigned RST_RATIO = RST_RATIO_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wr_valid,
  input  logic [RATIO_W-1:0] wr_ratio,
  input  logic               xfer,
  output logic               cmp_pulse,
  output logic               ref_out,
  output logic               wr_illegal,
  output logic               main_load,
  output logic [RATIO_W-1:0] act_ratio
);
  logic [RATIO_W-1:0] stage_q;
  logic               pending_q;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] active_q;
  logic               tc;
  logic               load;

  refdiv_ratio_buf #(.W(RATIO_W), .MIN_R(MIN_RATIO), .RST_R(RST_RATIO)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ratio  (wr_ratio),
    .xfer      (xfer),
    .commit    (load),
    .stage_q   (stage_q),
    .pending_q (pending_q),
    .illegal_q (wr_illegal)
  );

  refdiv_counter #(.W(RATIO_W), .RST_R(RST_RATIO)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pending  (pending_q),
    .stage    (stage_q),
    .cnt_q    (cnt_q),
    .active_q (active_q),
    .tc       (tc),
    .load     (load)
  );

  refdiv_refout #(.W(RATIO_W)) u_out (
    .clk       (clk),
    .en        (en),
    .tc        (tc),
    .cnt_q     (cnt_q),
    .active_q  (active_q),
    .cmp_pulse (cmp_pulse),
    .ref_out   (ref_out)
  );

  assign main_load = load;
  assign act_ratio = active_q;
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int unsigned W     = 13,
  parameter int unsigned MIN_R = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         xfer,
  input logic         cmp_pulse,
  input logic         ref_out,
  input logic         wr_illegal,
  input logic         main_load,
  input logic [W-1:0] act_ratio,
  input logic [W-1:0] stage_q,
  input logic         pending_q,
  input logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] MIN_V = W'(MIN_R);
  localparam logic [W-1:0] ONE_V = W'(1);

  AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ratio == ONE_V) || (act_ratio >= MIN_V)); // R1
  AST_REJECT_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |-> $stable(stage_q)); // R1
  AST_COUNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_ratio); // R3
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> en); // R3
  AST_RATIO_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !main_load |=> $stable(act_ratio)); // R4
  AST_LOAD_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (main_load && !xfer) |=> !pending_q); // R5
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R6
endmodule

bind refdiv_top refdiv_chk #(.W(RATIO_W), .MIN_R(MIN_RATIO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .xfer       (xfer),
  .cmp_pulse  (cmp_pulse),
  .ref_out    (ref_out),
  .wr_illegal (wr_illegal),
  .main_load  (main_load),
  .act_ratio  (act_ratio),
  .stage_q    (stage_q),
  .pending_q  (pending_q),
  .cnt_q      (cnt_q)
);

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;
  localparam int W = 13;
  localparam int NV = 11;
  // bit 13 = expected illegal flag, bits 12:0 = ratio
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 13'd5},  {1'b1, 13'd0}, {1'b0, 13'd7},    {1'b1, 13'd2},
    {1'b0, 13'd1},  {1'b1, 13'd3}, {1'b0, 13'd6},    {1'b1, 13'd4},
    {1'b0, 13'd13}, {1'b0, 13'd8191}, {1'b0, 13'd10}
  };

  logic         clk, rst_n, en, wr_valid, xfer;
  logic [W-1:0] wr_ratio;
  logic         cmp_pulse, ref_out, wr_illegal, main_load;
  logic [W-1:0] act_ratio;
  int total = 0;
  int bad = 0;
  int exp_ratio = 5;
  bit finished = 0;

  refdiv_top #(.RATIO_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_valid(wr_valid), .wr_ratio(wr_ratio),
    .xfer(xfer), .cmp_pulse(cmp_pulse), .ref_out(ref_out), .wr_illegal(wr_illegal),
    .main_load(main_load), .act_ratio(act_ratio)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge1;
    @(posedge clk); #1;
  endtask

  task automatic write_ratio(input int r);
    edge1(); wr_valid = 1'b1; wr_ratio = r[W-1:0];
    edge1(); wr_valid = 1'b0;
  endtask

  task automatic pulse_xfer;
    edge1(); xfer = 1'b1;
    edge1(); xfer = 1'b0;
  endtask

  task automatic wait_commit(output int n);
    int k = 0;
    n = 0;
    while (k < 20000) begin
      @(negedge clk); k++;
      if (main_load) begin n = k; break; end
    end
  endtask

  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    do begin
      @(negedge clk); per++;
      if (ref_out) hi++;
    end while (!cmp_pulse && per < 20000);
  endtask

  initial begin
    int n, per, hi;
    logic held;
    rst_n = 1'b0; en = 1'b0; wr_valid = 1'b0; xfer = 1'b0; wr_ratio = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(act_ratio == 5, "R2 reset ratio", act_ratio, 5);
    chk(wr_illegal == 0, "R2 reset flag", wr_illegal, 0);
    chk(main_load == 0, "R2 reset load", main_load, 0);
    chk(cmp_pulse == 0, "R2 no pulse while disabled", cmp_pulse, 0);
    edge1(); en = 1'b1;
    @(negedge clk);
    chk(cmp_pulse == 1, "R2 first enabled cycle is terminal", cmp_pulse, 1);
    measure(per, hi);
    chk(per == 5, "R3 reset ratio period", per, 5);

    // table of ratio writes, each followed by a transfer and a period measurement
    for (int i = 0; i < NV; i++) begin
      int r;
      bit ill;
      r = int'(VEC[i][12:0]);
      ill = VEC[i][13];
      write_ratio(r);
      @(negedge clk);
      chk(wr_illegal == ill, "R1 illegal flag", wr_illegal, ill);
      chk(act_ratio == exp_ratio, "R4 ratio held before transfer", act_ratio, exp_ratio);
      if (!ill) exp_ratio = r;
      pulse_xfer();
      chk(wr_illegal == 0, "R1 flag lasts one cycle", wr_illegal, 0);
      wait_commit(n);
      chk(n != 0, "R5 load strobe at terminal count", n, 1);
      measure(per, hi);
      chk(per == exp_ratio, "R5 period after commit", per, exp_ratio);
      chk(act_ratio == exp_ratio, "R5 active ratio after commit", act_ratio, exp_ratio);
      if (exp_ratio >= 5)
        chk(hi == (exp_ratio + 1) / 2, "R8 reference high time", hi, (exp_ratio + 1) / 2);
    end

    // R6: disabled stretch freezes count and output
    measure(per, hi);
    edge1(); en = 1'b0;
    @(negedge clk);
    held = ref_out;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      chk(cmp_pulse == 0, "R6 no pulse while disabled", cmp_pulse, 0);
      chk(ref_out == held, "R6 ref_out frozen", ref_out, held);
    end
    edge1(); en = 1'b1;

    // R4: staged write alone does not change the ratio
    write_ratio(7);
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      chk(act_ratio == 10 && main_load == 0, "R4 staged write without transfer", act_ratio, 10);
    end

    // R9: transfer landing on a terminal count with nothing pending
    measure(per, hi);
    repeat (10) @(posedge clk);
    #1 xfer = 1'b1;
    @(negedge clk);
    chk(cmp_pulse == 1 && main_load == 0, "R9 strobe on terminal count does not commit",
        main_load, 0);
    edge1(); xfer = 1'b0;
    wait_commit(n);
    chk(n == 10, "R9 commit at following terminal count", n, 10);
    measure(per, hi);
    chk(per == 7, "R5 new period after deferred commit", per, 7);

    // R7: ratio one bypass
    write_ratio(1);
    pulse_xfer();
    wait_commit(n);
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #2;
      chk(ref_out == 1, "R7 bypass follows clock high", ref_out, 1);
      @(negedge clk);
      chk(cmp_pulse == 1, "R7 pulse every cycle", cmp_pulse, 1);
      chk(ref_out == 0, "R7 bypass follows clock low", ref_out, 0);
    end
    @(posedge clk); #1 en = 1'b0;
    #1;
    chk(ref_out == 0, "R7 bypass gated by enable", ref_out, 0);
    @(negedge clk);
    chk(cmp_pulse == 0, "R3 no pulse with enable low", cmp_pulse, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule